// File: doc/BRIEF.md
# Time-Multiplexed Multiport Register File

This block gives a processor model a register file with three read ports and two write ports per target cycle, while the storage underneath is three banks that can each take only one read and one write per host cycle. A target cycle is spread over three busy host cycles. Registers are interleaved over the banks by address modulo three, so consecutive register numbers land in different banks.

A wrapper presents all port inputs and pulses `start_i` for one host cycle. The block latches the inputs, reads port 0, port 1 and port 2 in the three following host cycles, commits write port 0 in the third of them and write port 1 in the host cycle that follows, in which it raises `done_o` for one cycle. Every read sees the register contents from before the current target cycle's writes, and the read results stay on the outputs until the next target cycle starts overwriting them. A new `start_i` may be given in the cycle where `done_o` is high.

Top module: `tmrf_regfile`

## Requirements
- R1: Read port k (address field `rd_addr_i[k*AW +: AW]`, result field `rd_data_o[k*DATA_W +: DATA_W]`, k = 0..2) returns the value its register held before the current target cycle's writes.
- R2: An enabled write on port j (enable `wr_en_i[j]`, fields `wr_addr_i[j*AW +: AW]` and `wr_data_i[j*DATA_W +: DATA_W]`) is visible to reads in every later target cycle.
- R3: When both write ports are enabled for the same address in one target cycle, the register ends with the data of write port 1.
- R4: A read of an address that is written in the same target cycle returns the old contents, on every read port.
- R5: `done_o` is high for exactly one host cycle, in the fourth host cycle after the cycle in which an accepted `start_i` was high.
- R6: `start_i` is accepted only when the block is idle or `done_o` is high; a `start_i` during the three busy host cycles has no effect on results, on stored data or on the `done_o` timing.
- R7: `rd_data_o` changes only on the clock edges that end the three busy host cycles, so it is stable from `done_o` until after the next accepted start.
- R8: During and right after reset, `done_o` is low and `rd_data_o` is zero.
- R9: A write port whose enable bit is low leaves every register unchanged.
- R10: Each bank sees at most one read and one write per host cycle, including a target cycle whose three reads all fall into one bank (addresses equal modulo 3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse: all port inputs are valid for a new target cycle |
| rd_addr_i | input | 3*AW | Read addresses, port k in bits k*AW +: AW |
| wr_en_i | input | 2 | Write enables, bit j for write port j |
| wr_addr_i | input | 2*AW | Write addresses, port j in bits j*AW +: AW |
| wr_data_i | input | 2*DATA_W | Write data, port j in bits j*DATA_W +: DATA_W |
| done_o | output | 1 | One-cycle pulse: reads returned and writes committed |
| rd_data_o | output | 3*DATA_W | Read results, port k in bits k*DATA_W +: DATA_W |

## Verification
The assertions assume every address is below NUM_REGS and that `start_i` is a single-cycle pulse; they do not depend on the data values. The bench draws addresses as `$urandom` modulo the register count, never holds `start_i` for two cycles except when poking it deliberately during the busy window (where it is ignored by R6), and spaces target cycles by zero to three idle host cycles. Reads of registers not yet written are not compared, and a directed fill writes every register before the random phase.

// File: rtl/tmrf_pkg.sv
package tmrf_pkg;
   parameter int unsigned RD_PORTS = 3;
   parameter int unsigned WR_PORTS = 2;
   parameter int unsigned BANKS    = 3;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PH0  = 3'd1,
      ST_PH1  = 3'd2,
      ST_PH2  = 3'd3,
      ST_DONE = 3'd4
   } tmrf_state_e;
endpackage

// File: rtl/tmrf_bank.sv
module tmrf_bank #(
   parameter int unsigned DW   = 32,
   parameter int unsigned ROWS = 16,
   localparam int unsigned RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic          clk,
   input  logic          rd_en_i,
   input  logic [RW-1:0] rd_row_i,
   output logic [DW-1:0] rd_data_o,
   input  logic          wr_en_i,
   input  logic [RW-1:0] wr_row_i,
   input  logic [DW-1:0] wr_data_i
);
   logic [DW-1:0] mem [ROWS];

   // read sees the contents before a write committed on the same edge
   assign rd_data_o = rd_en_i ? mem[rd_row_i] : '0;

   always_ff @(posedge clk) begin
      if (wr_en_i) mem[wr_row_i] <= wr_data_i;
   end
endmodule

// File: rtl/tmrf_seq.sv
module tmrf_seq
   import tmrf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   output tmrf_state_e state_o,
   output logic        accept_o
);
   tmrf_state_e nxt;

   assign accept_o = start_i && (state_o == ST_IDLE || state_o == ST_DONE);

   always_comb begin
      unique case (state_o)
         ST_PH0:  nxt = ST_PH1;
         ST_PH1:  nxt = ST_PH2;
         ST_PH2:  nxt = ST_DONE;
         default: nxt = accept_o ? ST_PH0 : ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_o <= ST_IDLE;
      else        state_o <= nxt;
   end
endmodule

// File: rtl/tmrf_regfile.sv
module tmrf_regfile
   import tmrf_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 48,
   localparam int unsigned AW      = $clog2(NUM_REGS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic [RD_PORTS*AW-1:0]       rd_addr_i,
   input  logic [WR_PORTS-1:0]          wr_en_i,
   input  logic [WR_PORTS*AW-1:0]       wr_addr_i,
   input  logic [WR_PORTS*DATA_W-1:0]   wr_data_i,
   output logic                         done_o,
   output logic [RD_PORTS*DATA_W-1:0]   rd_data_o
);
   localparam int unsigned ROWS = NUM_REGS / BANKS;
   localparam int unsigned RW   = (ROWS > 1) ? $clog2(ROWS) : 1;

   generate
      if (NUM_REGS % BANKS != 0 || NUM_REGS < BANKS)
         $error("NUM_REGS must be a nonzero multiple of the bank count");
      if (DATA_W == 0)
         $error("DATA_W must be nonzero");
   endgenerate

   function automatic logic [1:0] bank_of(input logic [AW-1:0] a);
      logic [AW-1:0] m;
      m = a % AW'(BANKS);
      return m[1:0];
   endfunction

   function automatic logic [RW-1:0] row_of(input logic [AW-1:0] a);
      logic [AW-1:0] q;
      q = a / AW'(BANKS);
      return q[RW-1:0];
   endfunction

   tmrf_state_e state;
   logic        accept;
   logic        busy;

   tmrf_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .state_o  (state),
      .accept_o (accept)
   );

   // latched port inputs of the current target cycle
   logic [AW-1:0]     rd_addr_q [RD_PORTS];
   logic [AW-1:0]     wr_addr_q [WR_PORTS];
   logic [DATA_W-1:0] wr_data_q [WR_PORTS];
   logic [WR_PORTS-1:0] wr_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en_q <= '0;
         for (int p = 0; p < RD_PORTS; p++) rd_addr_q[p] <= '0;
         for (int p = 0; p < WR_PORTS; p++) begin
            wr_addr_q[p] <= '0;
            wr_data_q[p] <= '0;
         end
      end else if (accept) begin
         wr_en_q <= wr_en_i;
         for (int p = 0; p < RD_PORTS; p++) rd_addr_q[p] <= rd_addr_i[p*AW +: AW];
         for (int p = 0; p < WR_PORTS; p++) begin
            wr_addr_q[p] <= wr_addr_i[p*AW +: AW];
            wr_data_q[p] <= wr_data_i[p*DATA_W +: DATA_W];
         end
      end
   end

   // phase decode: read port k in busy phase k, write 0 in phase 2, write 1 in done cycle
   logic [1:0]        rd_idx;
   logic [AW-1:0]     rd_sel;
   logic              wr_act;
   logic [AW-1:0]     wr_sel;
   logic [DATA_W-1:0] wr_dsel;

   assign busy = (state == ST_PH0) || (state == ST_PH1) || (state == ST_PH2);

   always_comb begin
      rd_idx  = 2'd0;
      wr_act  = 1'b0;
      wr_sel  = wr_addr_q[0];
      wr_dsel = wr_data_q[0];
      case (state)
         ST_PH1: rd_idx = 2'd1;
         ST_PH2: begin
            rd_idx = 2'd2;
            wr_act = wr_en_q[0];
         end
         ST_DONE: begin
            wr_act  = wr_en_q[1];
            wr_sel  = wr_addr_q[1];
            wr_dsel = wr_data_q[1];
         end
         default: ;
      endcase
      rd_sel = rd_addr_q[rd_idx];
   end

   logic [BANKS-1:0]  bank_rd_en;
   logic [BANKS-1:0]  bank_wr_en;
   logic [DATA_W-1:0] bank_rdata [BANKS];

   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         assign bank_rd_en[b] = busy   && (bank_of(rd_sel) == 2'(b));
         assign bank_wr_en[b] = wr_act && (bank_of(wr_sel) == 2'(b));

         tmrf_bank #(.DW(DATA_W), .ROWS(ROWS)) u_bank (
            .clk       (clk),
            .rd_en_i   (bank_rd_en[b]),
            .rd_row_i  (row_of(rd_sel)),
            .rd_data_o (bank_rdata[b]),
            .wr_en_i   (bank_wr_en[b]),
            .wr_row_i  (row_of(wr_sel)),
            .wr_data_i (wr_dsel)
         );
      end
   endgenerate

   // result registers, one per read port
   logic [DATA_W-1:0] res_q [RD_PORTS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < RD_PORTS; p++) res_q[p] <= '0;
      end else begin
         for (int p = 0; p < RD_PORTS; p++)
            if (busy && rd_idx == 2'(p)) res_q[p] <= bank_rdata[bank_of(rd_sel)];
      end
   end

   generate
      for (genvar p = 0; p < RD_PORTS; p++) begin : g_out
         assign rd_data_o[p*DATA_W +: DATA_W] = res_q[p];
      end
   endgenerate

   assign done_o = (state == ST_DONE);
endmodule

// File: rtl/tmrf_chk.sv
module tmrf_chk #(
   parameter int unsigned DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          done_o,
   input logic [3*DW-1:0] rd_data_o,
   input logic [2:0]    bank_rd_en,
   input logic [2:0]    bank_wr_en,
   input logic          busy
);
   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R5
   done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(start_i, 4));

   // R7
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_data_o) |-> $past(busy));

   // R10
   one_read_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_rd_en));

   // R10
   one_write_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_wr_en));

   // R6
   no_read_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (bank_rd_en == 3'b000));
endmodule

bind tmrf_regfile tmrf_chk #(.DW(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .done_o     (done_o),
   .rd_data_o  (rd_data_o),
   .bank_rd_en (bank_rd_en),
   .bank_wr_en (bank_wr_en),
   .busy       (busy)
);

// File: tb/tmrf_regfile_tb.sv
module tmrf_regfile_tb;
   localparam int DW = 32;
   localparam int NR = 48;
   localparam int AW = $clog2(NR);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic [3*AW-1:0] rd_addr_i = '0;
   logic [1:0]      wr_en_i = '0;
   logic [2*AW-1:0] wr_addr_i = '0;
   logic [2*DW-1:0] wr_data_i = '0;
   logic            done_o;
   logic [3*DW-1:0] rd_data_o;

   always #2 clk = ~clk;

   tmrf_regfile #(.DATA_W(DW), .NUM_REGS(NR)) u_dut (.*);

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] model [NR];
   bit            valid [NR];

   task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] mdl_read(input int a);
      return model[a];
   endfunction

   // one target cycle; returns at the negedge where done is expected
   task automatic target(input int a0, input int a1, input int a2, input bit e0, input bit e1,
                         input int w0, input int w1, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                         input bit poke, input string rtag);
      logic [DW-1:0] exp [3];
      bit            ev [3];
      int            ra [3];
      ra[0] = a0; ra[1] = a1; ra[2] = a2;
      for (int k = 0; k < 3; k++) begin
         exp[k] = mdl_read(ra[k]);
         ev[k]  = valid[ra[k]];
      end
      rd_addr_i = {AW'(a2), AW'(a1), AW'(a0)};
      wr_en_i   = {e1, e0};
      wr_addr_i = {AW'(w1), AW'(w0)};
      wr_data_i = {d1, d0};
      start_i   = 1'b1;
      if (e0) begin model[w0] = d0; valid[w0] = 1; end
      if (e1) begin model[w1] = d1; valid[w1] = 1; end
      for (int c = 1; c <= 4; c++) begin
         @(negedge clk);
         start_i = 1'b0;
         if (poke && c < 4) begin
            // R6: start while busy with garbage inputs
            start_i   = 1'b1;
            rd_addr_i = {AW'((a0 + 7) % NR), AW'((a1 + 5) % NR), AW'((a2 + 3) % NR)};
            wr_en_i   = 2'b11;
            wr_addr_i = {AW'(a0), AW'(a1)};
            wr_data_i = {DW'(32'hDEAD0000 + c), DW'(32'hBEEF0000 + c)};
         end
         if (c < 4)
            check(done_o == 1'b0, poke ? "R6 done early" : "R5 done early", DW'(done_o), '0);
      end
      start_i = 1'b0;
      check(done_o == 1'b1, poke ? "R6 done timing" : "R5 done timing", DW'(done_o), 1);
      for (int k = 0; k < 3; k++)
         if (ev[k]) check(rd_data_o[k*DW +: DW] === exp[k], rtag, rd_data_o[k*DW +: DW], exp[k]);
   endtask

   task automatic idle(input int n);
      logic [3*DW-1:0] held;
      held = rd_data_o;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check(done_o == 1'b0, "R5 single pulse", DW'(done_o), '0);
         check(rd_data_o == held, "R7 hold", rd_data_o[DW-1:0], held[DW-1:0]);
      end
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < NR; i++) begin model[i] = '0; valid[i] = 0; end
      repeat (3) @(negedge clk);
      check(done_o == 1'b0, "R8 done in reset", DW'(done_o), '0);
      check(rd_data_o == '0, "R8 data in reset", rd_data_o[DW-1:0], '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done_o == 1'b0 && rd_data_o == '0, "R8 after reset", rd_data_o[DW-1:0], '0);

      // fill every register (R2)
      for (int i = 0; i < NR / 2; i++)
         target(0, 1, 2, 1, 1, 2*i, 2*i+1, DW'(32'h1000 + 2*i), DW'(32'h1000 + 2*i + 1), 0, "R2 fill");
      idle(2);
      target(0, 17, 47, 0, 0, 0, 0, '0, '0, 0, "R2 readback");
      // R10: all three reads in bank 0
      target(3, 6, 9, 0, 0, 0, 0, '0, '0, 0, "R10 same bank reads");
      // R3: both writes same address, port 1 wins
      target(1, 1, 1, 1, 1, 10, 10, 32'hAAAA0000, 32'hBBBB0000, 0, "R1");
      target(10, 10, 10, 0, 0, 0, 0, '0, '0, 0, "R3 port1 wins");
      // R4: reads of addresses written in the same target cycle
      target(20, 20, 20, 1, 1, 20, 21, 32'h44440000, 32'h55550000, 0, "R4 old value");
      target(21, 21, 20, 0, 0, 0, 0, '0, '0, 0, "R2 new value");
      // R9: disabled writes leave registers alone
      target(5, 6, 7, 0, 0, 5, 6, 32'hFFFF0001, 32'hFFFF0002, 0, "R1");
      idle(1);
      target(5, 6, 7, 0, 0, 0, 0, '0, '0, 0, "R9 no write");
      // R6: start poked while busy
      target(30, 31, 32, 1, 0, 30, 0, 32'h66660000, '0, 1, "R6 ignored start");
      target(30, 31, 32, 0, 0, 0, 0, '0, '0, 0, "R6 state intact");

      // random phase
      for (int n = 0; n < 400; n++) begin
         target($urandom % NR, $urandom % NR, $urandom % NR,
                1'($urandom), 1'($urandom), $urandom % NR, $urandom % NR,
                $urandom, $urandom, ($urandom % 4) == 0, "R1 random");
         idle($urandom % 4);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule